// File: doc/BRIEF.md
# Three-Window Memory BAR Address Translator

This block sits on the target side of a memory BAR and turns each BAR offset into an address in a 32-bit internal space. The BAR is cut into four regions. Two of them are fixed-size windows, called window A and window C, whose internal bases come from registers. A third window, window B, fills the rest of the BAR and is pageable: its internal base is a register that is aligned to the window size. Software moves window B by writing that register. The fourth region, between window C and window B, does not reach internal memory at all. It mirrors a slice of configuration space, so accesses there go to a separate config port.

A single access is taken at a time. The block latches the request together with its translated address, then holds it on the internal bus or on the config mirror port until that side acknowledges. One cycle after the acknowledge it signals completion and, for a read, presents the returned data. The bases are written through a small configuration write port that has a selector for each window. Offsets past the end of the BAR are completed locally and reach neither port.

Top module: `swin_bar_decoder`

## Requirements
- R1: After reset, `bar_busy`, `bar_done`, `ib_req` and `mir_req` are low, and the bases hold the reset parameters with the forced-zero low bits applied. Windows A and C have their low two bits forced to zero; window B has its low log2(`SWB_SIZE`) bits forced to zero.
- R2: An offset from 0x00 to 0x57 maps to internal address `baseA + offset`.
- R3: An offset from 0x58 to 0x5F maps to internal address `baseC + (offset - 0x58)`.
- R4: An offset from 0x60 to 0x7F raises `mir_req` with `mir_addr` equal to the low 8 bits of the offset, and raises no internal request.
- R5: An offset from 0x80 to 0x80+`SWB_SIZE`-1 maps to the upper bits of `baseB` joined with the low log2(`SWB_SIZE`) bits of `offset - 0x80`.
- R6: When `cfg_we` is high, `cfg_sel` picks the base to write: 0 is window A, 1 is window C and 2 is window B. The value 3 changes no base. The forced-zero low bits of R1 apply to every write.
- R7: `ib_we`, `ib_be` and `ib_wdata` carry the BAR access unchanged, so byte, word and dword sizes are kept. A request and all its fields stay stable until it is acknowledged.
- R8: `bar_done` is high in the cycle after the acknowledge cycle. For a read, `bar_rdata` in that cycle equals the data that came with the acknowledge.
- R9: An offset at or beyond 0x80+`SWB_SIZE` raises no request. `bar_done` is high in the cycle after acceptance, with `bar_rdata` equal to zero.
- R10: A `bar_req` pulse that arrives while `bar_busy` is high is ignored.
- R11: A base write in the same cycle that an access is accepted does not affect that access; it applies from the next access on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bar_req | input | 1 | One-cycle access request, taken when not busy |
| bar_we | input | 1 | 1 = write, 0 = read |
| bar_off | input | OFF_W | Byte offset into the BAR |
| bar_be | input | BE_W | Byte enables |
| bar_wdata | input | DATA_W | Write data |
| bar_busy | output | 1 | An access is in progress |
| bar_done | output | 1 | Access complete (one cycle) |
| bar_rdata | output | DATA_W | Read data, valid with bar_done |
| cfg_we | input | 1 | Base register write strobe |
| cfg_sel | input | 2 | Base select: 0 A, 1 C, 2 B, 3 none |
| cfg_wdata | input | IADDR_W | New base value |
| ib_req | output | 1 | Internal bus request |
| ib_we | output | 1 | Internal bus write |
| ib_addr | output | IADDR_W | Internal byte address |
| ib_be | output | BE_W | Internal byte enables |
| ib_wdata | output | DATA_W | Internal write data |
| ib_ack | input | 1 | Internal bus acknowledge |
| ib_rdata | input | DATA_W | Internal read data, valid with ib_ack |
| mir_req | output | 1 | Config mirror request |
| mir_we | output | 1 | Config mirror write |
| mir_addr | output | 8 | Config space byte address |
| mir_be | output | BE_W | Config mirror byte enables |
| mir_wdata | output | DATA_W | Config mirror write data |
| mir_ack | input | 1 | Config mirror acknowledge |
| mir_rdata | input | DATA_W | Config mirror read data |

## Verification
A window base write and the acceptance of a BAR access can land on the same clock edge. The decoder then has to translate with the base that held before that edge. The bench provokes this by raising `bar_req` and `cfg_we` on the same cycle, for window B and for window A. It expects the translated address to be built from the old base, and it expects the very next access to use the new, aligned base. Random runs also put base writes between accesses with random acknowledge delays, so that window moves mix with every region of the BAR.

// File: rtl/swin_pkg.sv
package swin_pkg;

   // Fixed BAR layout; the ordering of these starts is what the decoder relies on
   localparam int unsigned A_START   = 'h00;
   localparam int unsigned C_START   = 'h58;
   localparam int unsigned MIR_START = 'h60;
   localparam int unsigned B_START   = 'h80;

   // Base select codes on the configuration write port
   localparam logic [1:0] SEL_A = 2'd0;
   localparam logic [1:0] SEL_C = 2'd1;
   localparam logic [1:0] SEL_B = 2'd2;

   typedef enum logic [2:0] {
      RG_A,
      RG_C,
      RG_MIR,
      RG_B,
      RG_NONE
   } region_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_RESP
   } xfer_st_e;

endpackage

// File: rtl/swin_base_regs.sv
module swin_base_regs #(
   parameter int unsigned         IADDR_W   = 32,
   parameter int unsigned         SWB_LOG2  = 16,
   parameter int unsigned         LANE_LOG2 = 2,
   parameter logic [IADDR_W-1:0]  RST_A     = '0,
   parameter logic [IADDR_W-1:0]  RST_C     = '0,
   parameter logic [IADDR_W-1:0]  RST_B     = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [1:0]          cfg_sel,
   input  logic [IADDR_W-1:0]  cfg_wdata,
   output logic [IADDR_W-1:0]  base_a,
   output logic [IADDR_W-1:0]  base_c,
   output logic [IADDR_W-1:0]  base_b
);
   import swin_pkg::*;

   localparam int unsigned NWIN = 3;

   logic [IADDR_W-1:0] base_q [NWIN];

   // One register per window; index 0/1/2 equals the select code A/C/B
   for (genvar gi = 0; gi < NWIN; gi++) begin : g_win
      localparam int unsigned        ZB   = (gi == 2) ? SWB_LOG2 : LANE_LOG2;
      localparam logic [IADDR_W-1:0] KEEP = ~((IADDR_W'(1) << ZB) - IADDR_W'(1));
      localparam logic [IADDR_W-1:0] RSTV = (gi == 0) ? RST_A : ((gi == 1) ? RST_C : RST_B);

      logic [IADDR_W-1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= RSTV & KEEP;
         else if (cfg_we && (cfg_sel == 2'(gi)))
            q <= cfg_wdata & KEEP;
      end

      assign base_q[gi] = q;
   end

   assign base_a = base_q[SEL_A];
   assign base_c = base_q[SEL_C];
   assign base_b = base_q[SEL_B];

endmodule

// File: rtl/swin_decode.sv
module swin_decode #(
   parameter int unsigned IADDR_W  = 32,
   parameter int unsigned SWB_LOG2 = 16,
   parameter int unsigned OFF_W    = 17
) (
   input  logic [OFF_W-1:0]            off,
   input  logic [IADDR_W-1:0]          base_a,
   input  logic [IADDR_W-1:0]          base_c,
   input  logic [IADDR_W-SWB_LOG2-1:0] base_b_hi,
   output swin_pkg::region_e           region,
   output logic [IADDR_W-1:0]          iaddr,
   output logic [7:0]                  maddr
);
   import swin_pkg::*;

   localparam logic [OFF_W-1:0] C_O   = OFF_W'(C_START);
   localparam logic [OFF_W-1:0] M_O   = OFF_W'(MIR_START);
   localparam logic [OFF_W-1:0] B_O   = OFF_W'(B_START);
   localparam logic [OFF_W:0]   END_O = (OFF_W+1)'(B_START + (1 << SWB_LOG2));

   logic [OFF_W-1:0]    rel_c;
   logic [SWB_LOG2-1:0] rel_b;

   always_comb begin
      rel_c  = off - C_O;
      rel_b  = off[SWB_LOG2-1:0] - SWB_LOG2'(B_START);
      region = RG_NONE;
      iaddr  = '0;
      if (off < C_O) begin
         region = RG_A;
         iaddr  = base_a + IADDR_W'(off);
      end else if (off < M_O) begin
         region = RG_C;
         iaddr  = base_c + IADDR_W'(rel_c);
      end else if (off < B_O) begin
         region = RG_MIR;
      end else if ({1'b0, off} < END_O) begin
         // Base is size-aligned, so the page offset is spliced in, no carry chain
         region = RG_B;
         iaddr  = {base_b_hi, rel_b};
      end
   end

   assign maddr = off[7:0];

endmodule

// File: rtl/swin_xfer.sv
module swin_xfer #(
   parameter int unsigned IADDR_W = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned BE_W    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bar_req,
   input  logic                bar_we,
   input  logic [BE_W-1:0]     bar_be,
   input  logic [DATA_W-1:0]   bar_wdata,
   input  swin_pkg::region_e   region,
   input  logic [IADDR_W-1:0]  iaddr,
   input  logic [7:0]          maddr,
   output logic                bar_busy,
   output logic                bar_done,
   output logic [DATA_W-1:0]   bar_rdata,
   output logic                ib_req,
   output logic                mir_req,
   output logic                x_we,
   output logic [IADDR_W-1:0]  x_addr,
   output logic [7:0]          x_maddr,
   output logic [BE_W-1:0]     x_be,
   output logic [DATA_W-1:0]   x_wdata,
   input  logic                ib_ack,
   input  logic [DATA_W-1:0]   ib_rdata,
   input  logic                mir_ack,
   input  logic [DATA_W-1:0]   mir_rdata
);
   import swin_pkg::*;

   xfer_st_e           st_q;
   logic               to_mir_q;
   logic [DATA_W-1:0]  rdata_q;
   logic               ack_sel;
   logic [DATA_W-1:0]  rdata_sel;

   assign ack_sel   = to_mir_q ? mir_ack : ib_ack;
   assign rdata_sel = to_mir_q ? mir_rdata : ib_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         to_mir_q <= 1'b0;
         x_we     <= 1'b0;
         x_addr   <= '0;
         x_maddr  <= '0;
         x_be     <= '0;
         x_wdata  <= '0;
         rdata_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (bar_req) begin
                  x_we     <= bar_we;
                  x_be     <= bar_be;
                  x_wdata  <= bar_wdata;
                  x_addr   <= iaddr;
                  x_maddr  <= maddr;
                  to_mir_q <= (region == RG_MIR);
                  if (region == RG_NONE) begin
                     rdata_q <= '0;
                     st_q    <= ST_RESP;
                  end else begin
                     st_q    <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (ack_sel) begin
                  if (!x_we)
                     rdata_q <= rdata_sel;
                  st_q <= ST_RESP;
               end
            end
            ST_RESP: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign ib_req    = (st_q == ST_WAIT) && !to_mir_q;
   assign mir_req   = (st_q == ST_WAIT) &&  to_mir_q;
   assign bar_busy  = (st_q != ST_IDLE);
   assign bar_done  = (st_q == ST_RESP);
   assign bar_rdata = rdata_q;

endmodule

// File: rtl/swin_bar_decoder.sv
module swin_bar_decoder #(
   parameter int unsigned         IADDR_W  = 32,
   parameter int unsigned         DATA_W   = 32,
   parameter int unsigned         SWB_SIZE = 65536,
   parameter logic [IADDR_W-1:0]  RST_A    = '0,
   parameter logic [IADDR_W-1:0]  RST_C    = '0,
   parameter logic [IADDR_W-1:0]  RST_B    = '0,
   localparam int unsigned        BE_W     = DATA_W / 8,
   localparam int unsigned        OFF_W    = $clog2(swin_pkg::B_START + SWB_SIZE)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bar_req,
   input  logic                bar_we,
   input  logic [OFF_W-1:0]    bar_off,
   input  logic [BE_W-1:0]     bar_be,
   input  logic [DATA_W-1:0]   bar_wdata,
   output logic                bar_busy,
   output logic                bar_done,
   output logic [DATA_W-1:0]   bar_rdata,
   input  logic                cfg_we,
   input  logic [1:0]          cfg_sel,
   input  logic [IADDR_W-1:0]  cfg_wdata,
   output logic                ib_req,
   output logic                ib_we,
   output logic [IADDR_W-1:0]  ib_addr,
   output logic [BE_W-1:0]     ib_be,
   output logic [DATA_W-1:0]   ib_wdata,
   input  logic                ib_ack,
   input  logic [DATA_W-1:0]   ib_rdata,
   output logic                mir_req,
   output logic                mir_we,
   output logic [7:0]          mir_addr,
   output logic [BE_W-1:0]     mir_be,
   output logic [DATA_W-1:0]   mir_wdata,
   input  logic                mir_ack,
   input  logic [DATA_W-1:0]   mir_rdata
);
   import swin_pkg::*;

   localparam int unsigned SWB_LOG2  = $clog2(SWB_SIZE);
   localparam int unsigned LANE_LOG2 = $clog2(BE_W);

   // Elaboration-time parameter checks
   if ((1 << SWB_LOG2) != SWB_SIZE) begin : g_bad_swb_pow2
      $error("SWB_SIZE must be a power of two");
   end
   if (SWB_LOG2 < 3 || SWB_LOG2 >= IADDR_W) begin : g_bad_swb_range
      $error("SWB_SIZE must be at least 8 bytes and below the internal space");
   end
   if (DATA_W % 8 != 0 || (1 << LANE_LOG2) != BE_W) begin : g_bad_data_w
      $error("DATA_W must be a power-of-two number of bytes");
   end
   if (SWB_LOG2 < LANE_LOG2) begin : g_bad_lanes
      $error("window B must be at least one data word wide");
   end

   logic [IADDR_W-1:0] base_a;
   logic [IADDR_W-1:0] base_c;
   logic [IADDR_W-1:0] base_b;
   region_e            region;
   logic [IADDR_W-1:0] iaddr;
   logic [7:0]         maddr;
   logic               x_we;
   logic [IADDR_W-1:0] x_addr;
   logic [7:0]         x_maddr;
   logic [BE_W-1:0]    x_be;
   logic [DATA_W-1:0]  x_wdata;

   swin_base_regs #(
      .IADDR_W   (IADDR_W),
      .SWB_LOG2  (SWB_LOG2),
      .LANE_LOG2 (LANE_LOG2),
      .RST_A     (RST_A),
      .RST_C     (RST_C),
      .RST_B     (RST_B)
   ) u_bases (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .base_a    (base_a),
      .base_c    (base_c),
      .base_b    (base_b)
   );

   swin_decode #(
      .IADDR_W   (IADDR_W),
      .SWB_LOG2  (SWB_LOG2),
      .OFF_W     (OFF_W)
   ) u_dec (
      .off       (bar_off),
      .base_a    (base_a),
      .base_c    (base_c),
      .base_b_hi (base_b[IADDR_W-1:SWB_LOG2]),
      .region    (region),
      .iaddr     (iaddr),
      .maddr     (maddr)
   );

   swin_xfer #(
      .IADDR_W   (IADDR_W),
      .DATA_W    (DATA_W),
      .BE_W      (BE_W)
   ) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bar_req   (bar_req),
      .bar_we    (bar_we),
      .bar_be    (bar_be),
      .bar_wdata (bar_wdata),
      .region    (region),
      .iaddr     (iaddr),
      .maddr     (maddr),
      .bar_busy  (bar_busy),
      .bar_done  (bar_done),
      .bar_rdata (bar_rdata),
      .ib_req    (ib_req),
      .mir_req   (mir_req),
      .x_we      (x_we),
      .x_addr    (x_addr),
      .x_maddr   (x_maddr),
      .x_be      (x_be),
      .x_wdata   (x_wdata),
      .ib_ack    (ib_ack),
      .ib_rdata  (ib_rdata),
      .mir_ack   (mir_ack),
      .mir_rdata (mir_rdata)
   );

   assign ib_we     = x_we;
   assign ib_addr   = x_addr;
   assign ib_be     = x_be;
   assign ib_wdata  = x_wdata;
   assign mir_we    = x_we;
   assign mir_addr  = x_maddr;
   assign mir_be    = x_be;
   assign mir_wdata = x_wdata;

endmodule

// File: rtl/swin_bar_decoder_chk.sv
module swin_bar_decoder_chk #(
   parameter int unsigned IADDR_W  = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned SWB_SIZE = 65536,
   parameter int unsigned OFF_W    = 17,
   parameter int unsigned BE_W     = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bar_req,
   input logic [OFF_W-1:0]    bar_off,
   input logic                bar_busy,
   input logic                bar_done,
   input logic [DATA_W-1:0]   bar_rdata,
   input logic                ib_req,
   input logic                ib_ack,
   input logic                ib_we,
   input logic [IADDR_W-1:0]  ib_addr,
   input logic [BE_W-1:0]     ib_be,
   input logic [DATA_W-1:0]   ib_wdata,
   input logic                mir_req,
   input logic                mir_ack,
   input logic [7:0]          mir_addr
);
   import swin_pkg::*;

   localparam int unsigned SWB_LOG2 = $clog2(SWB_SIZE);
   localparam logic [OFF_W:0] END_O = (OFF_W+1)'(B_START + SWB_SIZE);

   logic                accept;
   logic                in_mir;
   logic                in_b;
   logic                out_rng;
   logic [SWB_LOG2-1:0] page_off;

   assign accept   = bar_req && !bar_busy;
   assign in_mir   = (bar_off >= OFF_W'(MIR_START)) && (bar_off < OFF_W'(B_START));
   assign in_b     = (bar_off >= OFF_W'(B_START)) && ({1'b0, bar_off} < END_O);
   assign out_rng  = ({1'b0, bar_off} >= END_O);
   assign page_off = bar_off[SWB_LOG2-1:0] - SWB_LOG2'(B_START);

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bar_busy |-> (!ib_req && !mir_req && !bar_done)); // R1

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ib_req, mir_req})); // R4

   AST_MIR_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_mir) |=> (mir_req && !ib_req && (mir_addr == $past(bar_off[7:0])))); // R4

   AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_b) |=> (ib_req && (ib_addr[SWB_LOG2-1:0] == $past(page_off)))); // R5

   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (ib_req && !ib_ack) |=> (ib_req && $stable(ib_addr) && $stable(ib_be)
                               && $stable(ib_we) && $stable(ib_wdata))); // R7

   AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ((ib_req && ib_ack) || (mir_req && mir_ack)) |=> bar_done); // R8

   AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && out_rng) |=> (bar_done && !ib_req && !mir_req && (bar_rdata == '0))); // R9

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_busy && !bar_done) |=> bar_busy); // R10

endmodule

bind swin_bar_decoder swin_bar_decoder_chk #(
   .IADDR_W  (IADDR_W),
   .DATA_W   (DATA_W),
   .SWB_SIZE (SWB_SIZE),
   .OFF_W    (OFF_W),
   .BE_W     (BE_W)
) u_chk (.*);

// File: tb/swin_bar_decoder_test.sv
`timescale 1ns/1ps
module swin_bar_decoder_test;

   localparam int unsigned SWB   = 65536;
   localparam int unsigned OFF_W = $clog2(128 + SWB);
   localparam logic [31:0] RA = 32'h0010_0003;
   localparam logic [31:0] RC = 32'h0020_0106;
   localparam logic [31:0] RB = 32'h8001_2345;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bar_req = 1'b0;
   logic              bar_we = 1'b0;
   logic [OFF_W-1:0]  bar_off = '0;
   logic [3:0]        bar_be = '0;
   logic [31:0]       bar_wdata = '0;
   logic              bar_busy;
   logic              bar_done;
   logic [31:0]       bar_rdata;
   logic              cfg_we = 1'b0;
   logic [1:0]        cfg_sel = '0;
   logic [31:0]       cfg_wdata = '0;
   logic              ib_req;
   logic              ib_we;
   logic [31:0]       ib_addr;
   logic [3:0]        ib_be;
   logic [31:0]       ib_wdata;
   logic              ib_ack = 1'b0;
   logic [31:0]       ib_rdata = '0;
   logic              mir_req;
   logic              mir_we;
   logic [7:0]        mir_addr;
   logic [3:0]        mir_be;
   logic [31:0]       mir_wdata;
   logic              mir_ack = 1'b0;
   logic [31:0]       mir_rdata = '0;

   always #2.5 clk = ~clk;

   swin_bar_decoder #(
      .SWB_SIZE (SWB),
      .RST_A    (RA),
      .RST_C    (RC),
      .RST_B    (RB)
   ) uut (.*);

   int          n_chk = 0;
   int          n_bad = 0;
   bit          finished = 1'b0;
   logic [31:0] m_a, m_c, m_b;

   function automatic int region_of(int unsigned off);
      if (off < 'h58) return 0;
      if (off < 'h60) return 1;
      if (off < 'h80) return 2;
      if (off < 'h80 + SWB) return 3;
      return 4;
   endfunction

   function automatic string tag_of(int rg);
      case (rg)
         0: return "R2";
         1: return "R3";
         2: return "R4";
         3: return "R5";
         default: return "R9";
      endcase
   endfunction

   function automatic logic [31:0] exp_addr(int unsigned off);
      case (region_of(off))
         0: return m_a + off;
         1: return m_c + (off - 'h58);
         3: return m_b | (off - 'h80);
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] mem_data(logic [31:0] a);
      return {a[7:0], a[31:8]} ^ 32'h3C5A_A5C3;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   task automatic model_cfg(input logic [1:0] s, input logic [31:0] v);
      case (s)
         2'd0: m_a = v & ~32'h3;
         2'd1: m_c = v & ~32'h3;
         2'd2: m_b = v & ~(SWB - 1);
         default: ;
      endcase
   endtask

   task automatic cfg_write(input logic [1:0] s, input logic [31:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      model_cfg(s, v);
   endtask

   // One BAR access with bench-side responder; optional same-cycle base write
   // and optional extra bar_req pulse while busy.
   task automatic access(input int unsigned off, input bit we, input logic [3:0] be,
                         input logic [31:0] wd, input int dly, input string tag_in,
                         input bit same_cfg, input logic [1:0] csel, input logic [31:0] cval,
                         input bit poke);
      int          rg;
      logic [31:0] ea;
      logic [31:0] rd;
      string       tg;
      int          left;
      rg = region_of(off);
      ea = exp_addr(off);
      tg = (tag_in == "") ? tag_of(rg) : tag_in;
      @(negedge clk);
      bar_req = 1'b1; bar_off = OFF_W'(off); bar_we = we; bar_be = be; bar_wdata = wd;
      if (same_cfg) begin
         cfg_we = 1'b1; cfg_sel = csel; cfg_wdata = cval;
      end
      @(negedge clk);
      bar_req = 1'b0; cfg_we = 1'b0;
      if (same_cfg) model_cfg(csel, cval);
      if (rg == 4) begin
         chk(tg, 32'(bar_done), 32'd1, "done after out-of-range");
         chk(tg, 32'({ib_req, mir_req}), 32'd0, "no request");
         chk(tg, bar_rdata, 32'd0, "zero data");
      end else begin
         if (rg == 2) begin
            chk(tg, 32'({mir_req, ib_req}), 32'b10, "mirror only");
            chk(tg, 32'(mir_addr), off & 32'hFF, "mirror addr");
            rd = 32'h00C0_FF00 | (off & 32'hFF);
         end else begin
            chk(tg, 32'({mir_req, ib_req}), 32'b01, "internal only");
            chk(tg, ib_addr, ea, "internal addr");
            chk("R7", {27'd0, ib_we, ib_be}, {27'd0, we, be}, "we/be");
            chk("R7", ib_wdata, wd, "wdata");
            rd = mem_data(ea);
         end
         left = dly;
         if (poke && left > 0) begin
            bar_req = 1'b1; bar_off = OFF_W'('h10); bar_we = ~we;
            @(negedge clk);
            bar_req = 1'b0;
            left--;
         end
         repeat (left) @(negedge clk);
         if (rg != 2) chk("R7", ib_addr, ea, "addr held until ack");
         if (rg == 2) begin mir_ack = 1'b1; mir_rdata = rd; end
         else begin ib_ack = 1'b1; ib_rdata = rd; end
         @(negedge clk);
         mir_ack = 1'b0; ib_ack = 1'b0;
         chk("R8", 32'(bar_done), 32'd1, "done one cycle after ack");
         if (!we) chk("R8", bar_rdata, rd, "read data");
      end
      @(negedge clk);
      chk(poke ? "R10" : "R8", 32'({bar_busy, bar_done, ib_req, mir_req}), 32'd0,
          "idle after completion");
   endtask

   initial begin
      #(200000 * 5.0);
      if (!finished) begin
         n_bad++;
         $display("FAIL R8 watchdog act=running exp=finished");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      m_a = RA & ~32'h3;
      m_c = RC & ~32'h3;
      m_b = RB & ~(SWB - 1);

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", 32'({bar_busy, bar_done, ib_req, mir_req}), 32'd0, "outputs in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", 32'({bar_busy, bar_done, ib_req, mir_req}), 32'd0, "outputs after reset");
      access('h00, 1'b0, 4'hF, 0, 0, "R1", 0, 0, 0, 0);
      access('h80, 1'b0, 4'hF, 0, 1, "R1", 0, 0, 0, 0);
      access('h58, 1'b0, 4'hF, 0, 0, "R1", 0, 0, 0, 0);

      // Region boundaries
      access('h57, 1'b1, 4'h8, 32'hAA00_0000, 2, "", 0, 0, 0, 0);
      access('h58, 1'b0, 4'h1, 0, 0, "", 0, 0, 0, 0);
      access('h5F, 1'b1, 4'h8, 32'h1100_0000, 1, "", 0, 0, 0, 0);
      access('h60, 1'b0, 4'hF, 0, 3, "", 0, 0, 0, 0);
      access('h7F, 1'b1, 4'h8, 32'h5500_0000, 0, "", 0, 0, 0, 0);
      access('h80 + SWB - 1, 1'b0, 4'h8, 0, 2, "", 0, 0, 0, 0);
      access('h80 + SWB, 1'b0, 4'hF, 0, 0, "", 0, 0, 0, 0);
      access((1 << OFF_W) - 1, 1'b1, 4'hF, 32'hDEAD_BEEF, 0, "", 0, 0, 0, 0);

      // R6: selector 3 changes nothing; B write loses its low bits
      cfg_write(2'd3, 32'hFFFF_FFFF);
      access('h10, 1'b0, 4'hF, 0, 0, "R6", 0, 0, 0, 0);
      access('h5C, 1'b0, 4'hF, 0, 0, "R6", 0, 0, 0, 0);
      access('h90, 1'b0, 4'hF, 0, 0, "R6", 0, 0, 0, 0);
      cfg_write(2'd2, 32'h1234_5678);
      access('h80 + 'h10, 1'b0, 4'h3, 0, 1, "R6", 0, 0, 0, 0);
      chk("R6", m_b, 32'h1234_0000, "model base");
      cfg_write(2'd0, 32'h0000_F00F);
      access('h04, 1'b1, 4'h3, 32'h0000_1234, 0, "R6", 0, 0, 0, 0);

      // R11: base write on the same edge as acceptance
      access('h80 + 'h44, 1'b0, 4'hF, 0, 1, "R11", 1, 2'd2, 32'h7777_0000, 0);
      access('h80 + 'h44, 1'b0, 4'hF, 0, 0, "R11", 0, 0, 0, 0);
      access('h20, 1'b1, 4'hC, 32'hCAFE_0000, 0, "R11", 1, 2'd0, 32'h0300_0000, 0);
      access('h20, 1'b0, 4'hF, 0, 0, "R11", 0, 0, 0, 0);

      // R10: request pulse while busy
      access('h80 + 'h100, 1'b0, 4'hF, 0, 3, "R10", 0, 0, 0, 1);
      access('h64, 1'b1, 4'h2, 32'h0000_AB00, 2, "R10", 0, 0, 0, 1);

      // Random mix
      for (int i = 0; i < 400; i++) begin
         int unsigned sel;
         int unsigned off;
         logic [3:0]  be;
         sel = $urandom_range(0, 9);
         if (sel <= 2)      off = $urandom_range(0, 'h57);
         else if (sel == 3) off = $urandom_range('h58, 'h5F);
         else if (sel == 4) off = $urandom_range('h60, 'h7F);
         else if (sel <= 8) off = 'h80 + ($urandom % SWB);
         else               off = $urandom_range('h80 + SWB, (1 << OFF_W) - 1);
         case ($urandom_range(0, 6))
            0: be = 4'h1; 1: be = 4'h2; 2: be = 4'h4; 3: be = 4'h8;
            4: be = 4'h3; 5: be = 4'hC; default: be = 4'hF;
         endcase
         if ($urandom_range(0, 3) == 0)
            cfg_write(2'($urandom_range(0, 3)), $urandom);
         access(off, 1'($urandom), be, $urandom, $urandom_range(0, 3), "", 0, 0, 0,
                1'($urandom_range(0, 4) == 0));
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule